// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block decides which value a fused multiply-add `(a*b)+c` must return when NaN handling applies. It receives a class code for each of the three operands (ordinary value, quiet NaN or signaling NaN). It also receives a flag that marks the product as infinity times zero. It returns a 2-bit selection code. The code tells the surrounding datapath to forward operand a, b or c, or to build the default NaN. Muxing and quieting of the operand bits stay in that datapath. This block only produces the code.

A mode input picks one of six architectural policies. Each policy has its own treatment of the infinity-times-zero product and its own priority order among the operands. One policy also uses a first-NaN option bit. Besides the code, the block raises an invalid-operation indication in the same cycle, combinationally. A registered copy of that indication is collected into a sticky flag. Software-side logic can clear the sticky flag with a synchronous clear input.

Top module: `fma_nan_select`

## Requirements
- R1: Class codes are 2'b00 ordinary, 2'b01 quiet NaN, 2'b10 signaling NaN, and 2'b11 is treated as ordinary. Selection codes are 0 = a, 1 = b, 2 = c, 3 = default NaN.
- R2: Mode 0: with the inf*zero flag set and c a quiet NaN, the block outputs 3 with invalid. Otherwise invalid stays low and the first match wins in this order: c signaling, a signaling, b signaling, c quiet, a quiet. If none match, the code is b.
- R3: Mode 1: any inf*zero case outputs 3 with invalid. Otherwise signaling NaNs are chosen in the order a, b, c, then quiet NaNs in the order a, b. If none match, the code is c.
- R4: Mode 2: inf*zero outputs 2 with invalid. Otherwise the order is c signaling, a signaling, b signaling, c quiet, a quiet. If none match, the code is b.
- R5: Mode 3: inf*zero outputs 2 with invalid. Otherwise the code is a if a is any NaN, else c if c is any NaN, else b.
- R6: Mode 4: inf*zero outputs 2 with invalid. Otherwise, with first_nan high, the any-NaN order is a, b, c with c as the final case. With first_nan low, the order is c, b, a with a as the final case.
- R7: Modes 5 to 7: the code is a, b or c, whichever is the first to be any NaN, else c. Invalid is never raised and the inf*zero flag has no effect.
- R8: first_nan has no effect on the code in any mode other than 4.
- R9: invalid_now follows the inputs in the same cycle. invalid_sticky rises at the second rising clock edge after an invalid condition is present at an edge.
- R10: invalid_sticky holds until flag_clr is high at an edge, and then drops. An invalid condition that was registered at the previous edge wins over a clear in the same cycle, so the flag stays set.
- R11: Reset (rst_n low, asynchronous) clears the registered invalid copy and invalid_sticky. Invalid conditions present during reset are not collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cls_a | input | 2 | Class code of operand a |
| cls_b | input | 2 | Class code of operand b |
| cls_c | input | 2 | Class code of addend c |
| inf_zero | input | 1 | Product is infinity times zero |
| mode | input | 3 | Policy select |
| first_nan | input | 1 | First-NaN option used by mode 4 |
| flag_clr | input | 1 | Synchronous clear of the sticky flag |
| sel | output | 2 | Selection code |
| invalid_now | output | 1 | Combinational invalid indication |
| invalid_sticky | output | 1 | Accumulated invalid flag |

## Verification
The sticky flag can be cleared in the same cycle as a new invalid condition reaches it through the registered copy. The bench provokes this by first setting the flag. It then holds an invalid condition across one edge, and raises flag_clr on the following cycle with neutral inputs. The flag must still read set after that edge, and must read clear only one edge later, once the registered copy has emptied.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

    localparam int CLS_W  = 2;
    localparam int MODE_W = 3;
    localparam int SEL_W  = 2;
    localparam int N_OPS  = 3;

    typedef logic [CLS_W-1:0] cls_t;
    typedef logic [SEL_W-1:0] sel_t;

    localparam cls_t CLS_QUIET = 2'b01;
    localparam cls_t CLS_SIG   = 2'b10;

    localparam sel_t SEL_A   = 2'd0;
    localparam sel_t SEL_B   = 2'd1;
    localparam sel_t SEL_C   = 2'd2;
    localparam sel_t SEL_DEF = 2'd3;

    typedef enum logic [MODE_W-1:0] {
        POL_CFIRST  = 3'd0,
        POL_LEGACY  = 3'd1,
        POL_REVISED = 3'd2,
        POL_ANYNAN  = 3'd3,
        POL_CONFIG  = 3'd4
    } policy_e;

    typedef struct packed {
        logic inv;
        logic sticky;
    } flag_st_t;

endpackage

// File: rtl/fma_nan_cls_dec.sv
module fma_nan_cls_dec
    import fma_nan_pkg::*;
(
    input  cls_t cls_i,
    output logic quiet_o,
    output logic sig_o
);
    // the spare code 2'b11 decodes to neither kind of NaN
    always_comb begin
        quiet_o = (cls_i == CLS_QUIET);
        sig_o   = (cls_i == CLS_SIG);
    end
endmodule

// File: rtl/fma_nan_policy.sv
module fma_nan_policy
    import fma_nan_pkg::*;
(
    input  logic [N_OPS-1:0] quiet_i,   // index 0 = a, 1 = b, 2 = c
    input  logic [N_OPS-1:0] sig_i,
    input  logic             inf_zero_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic             first_nan_i,
    output sel_t             sel_o,
    output logic             inv_o
);
    logic [N_OPS-1:0] any_nan;
    policy_e          pol;

    always_comb begin
        any_nan = quiet_i | sig_i;
        pol     = policy_e'(mode_i);
        sel_o   = SEL_C;
        inv_o   = 1'b0;
        case (pol)
            POL_CFIRST: begin
                if (inf_zero_i && quiet_i[2]) begin
                    sel_o = SEL_DEF;
                    inv_o = 1'b1;
                end
                else if (sig_i[2])   sel_o = SEL_C;
                else if (sig_i[0])   sel_o = SEL_A;
                else if (sig_i[1])   sel_o = SEL_B;
                else if (quiet_i[2]) sel_o = SEL_C;
                else if (quiet_i[0]) sel_o = SEL_A;
                else                 sel_o = SEL_B;
            end
            POL_LEGACY: begin
                if (inf_zero_i) begin
                    sel_o = SEL_DEF;
                    inv_o = 1'b1;
                end
                else if (sig_i[0])   sel_o = SEL_A;
                else if (sig_i[1])   sel_o = SEL_B;
                else if (sig_i[2])   sel_o = SEL_C;
                else if (quiet_i[0]) sel_o = SEL_A;
                else if (quiet_i[1]) sel_o = SEL_B;
                else                 sel_o = SEL_C;
            end
            POL_REVISED: begin
                if (inf_zero_i) begin
                    sel_o = SEL_C;
                    inv_o = 1'b1;
                end
                else if (sig_i[2])   sel_o = SEL_C;
                else if (sig_i[0])   sel_o = SEL_A;
                else if (sig_i[1])   sel_o = SEL_B;
                else if (quiet_i[2]) sel_o = SEL_C;
                else if (quiet_i[0]) sel_o = SEL_A;
                else                 sel_o = SEL_B;
            end
            POL_ANYNAN: begin
                if (inf_zero_i) begin
                    sel_o = SEL_C;
                    inv_o = 1'b1;
                end
                else if (any_nan[0]) sel_o = SEL_A;
                else if (any_nan[2]) sel_o = SEL_C;
                else                 sel_o = SEL_B;
            end
            POL_CONFIG: begin
                if (inf_zero_i) begin
                    sel_o = SEL_C;
                    inv_o = 1'b1;
                end
                else if (first_nan_i) begin
                    if (any_nan[0])      sel_o = SEL_A;
                    else if (any_nan[1]) sel_o = SEL_B;
                    else                 sel_o = SEL_C;
                end
                else begin
                    if (any_nan[2])      sel_o = SEL_C;
                    else if (any_nan[1]) sel_o = SEL_B;
                    else                 sel_o = SEL_A;
                end
            end
            default: begin
                if (any_nan[0])      sel_o = SEL_A;
                else if (any_nan[1]) sel_o = SEL_B;
                else                 sel_o = SEL_C;
            end
        endcase
    end
endmodule

// File: rtl/fma_nan_sticky.sv
module fma_nan_sticky
    import fma_nan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inv_i,
    input  logic clr_i,
    output logic sticky_o
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.inv    = inv_i;
        // a pending registered event beats a clear in the same cycle
        st_d.sticky = (clr_i ? 1'b0 : st_q.sticky) | st_q.inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sticky_o = st_q.sticky;

    // R9
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.inv |=> st_q.sticky);
    // R10
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !st_q.inv) |=> !st_q.sticky);
    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sticky && !clr_i) |=> st_q.sticky);
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
    import fma_nan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cls_a,
    input  logic [1:0]  cls_b,
    input  logic [1:0]  cls_c,
    input  logic        inf_zero,
    input  logic [2:0]  mode,
    input  logic        first_nan,
    input  logic        flag_clr,
    output logic [1:0]  sel,
    output logic        invalid_now,
    output logic        invalid_sticky
);
    cls_t             cls_all [N_OPS];
    logic [N_OPS-1:0] quiet_w;
    logic [N_OPS-1:0] sig_w;

    assign cls_all[0] = cls_a;
    assign cls_all[1] = cls_b;
    assign cls_all[2] = cls_c;

    for (genvar i = 0; i < N_OPS; i++) begin : g_dec
        fma_nan_cls_dec u_dec (
            .cls_i   (cls_all[i]),
            .quiet_o (quiet_w[i]),
            .sig_o   (sig_w[i])
        );
    end

    fma_nan_policy u_policy (
        .quiet_i     (quiet_w),
        .sig_i       (sig_w),
        .inf_zero_i  (inf_zero),
        .mode_i      (mode),
        .first_nan_i (first_nan),
        .sel_o       (sel),
        .inv_o       (invalid_now)
    );

    fma_nan_sticky u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv_i    (invalid_now),
        .clr_i    (flag_clr),
        .sticky_o (invalid_sticky)
    );

    // R7
    fallback_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode >= 3'd5) |-> !invalid_now);
    // R2 R3
    default_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_DEF) |-> (invalid_now && inf_zero && mode <= 3'd1));
    // R5
    anynan_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && !inf_zero && (quiet_w[0] || sig_w[0])) |-> (sel == SEL_A));
endmodule

// File: tb/fma_nan_select_tb.sv
module fma_nan_select_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cls_a, cls_b, cls_c;
    logic       inf_zero, first_nan, flag_clr;
    logic [2:0] mode;
    logic [1:0] sel;
    logic       invalid_now, invalid_sticky;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    fma_nan_select u_dut (
        .clk(clk), .rst_n(rst_n), .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c),
        .inf_zero(inf_zero), .mode(mode), .first_nan(first_nan),
        .flag_clr(flag_clr), .sel(sel), .invalid_now(invalid_now),
        .invalid_sticky(invalid_sticky)
    );

    // {req, mode, first_nan, inf_zero, a, b, c, exp_sel, exp_inv}
    // class: 0 ordinary, 1 quiet, 2 signaling, 3 spare
    localparam int NV = 41;
    localparam logic [17:0] VEC [NV] = '{
        // R2
        {4'd2,3'd0,1'b0,1'b1,2'd0,2'd0,2'd1,2'd3,1'b1},
        {4'd2,3'd0,1'b0,1'b1,2'd0,2'd0,2'd2,2'd2,1'b0},
        {4'd2,3'd0,1'b0,1'b0,2'd2,2'd2,2'd1,2'd0,1'b0},
        {4'd2,3'd0,1'b0,1'b0,2'd1,2'd2,2'd1,2'd1,1'b0},
        {4'd2,3'd0,1'b0,1'b0,2'd1,2'd1,2'd1,2'd2,1'b0},
        {4'd2,3'd0,1'b0,1'b0,2'd0,2'd1,2'd0,2'd1,1'b0},
        {4'd2,3'd0,1'b0,1'b0,2'd0,2'd0,2'd0,2'd1,1'b0},
        {4'd2,3'd0,1'b0,1'b1,2'd0,2'd0,2'd0,2'd1,1'b0},
        // R3
        {4'd3,3'd1,1'b0,1'b1,2'd0,2'd0,2'd0,2'd3,1'b1},
        {4'd3,3'd1,1'b0,1'b0,2'd1,2'd1,2'd2,2'd2,1'b0},
        {4'd3,3'd1,1'b0,1'b0,2'd1,2'd2,2'd2,2'd1,1'b0},
        {4'd3,3'd1,1'b0,1'b0,2'd0,2'd1,2'd1,2'd1,1'b0},
        {4'd3,3'd1,1'b0,1'b0,2'd0,2'd0,2'd0,2'd2,1'b0},
        {4'd3,3'd1,1'b0,1'b0,2'd2,2'd1,2'd1,2'd0,1'b0},
        // R4
        {4'd4,3'd2,1'b0,1'b1,2'd1,2'd0,2'd0,2'd2,1'b1},
        {4'd4,3'd2,1'b0,1'b0,2'd2,2'd2,2'd2,2'd2,1'b0},
        {4'd4,3'd2,1'b0,1'b0,2'd1,2'd2,2'd1,2'd1,1'b0},
        {4'd4,3'd2,1'b0,1'b0,2'd1,2'd0,2'd1,2'd2,1'b0},
        {4'd4,3'd2,1'b0,1'b0,2'd0,2'd0,2'd0,2'd1,1'b0},
        // R5
        {4'd5,3'd3,1'b0,1'b1,2'd0,2'd0,2'd0,2'd2,1'b1},
        {4'd5,3'd3,1'b0,1'b0,2'd1,2'd2,2'd2,2'd0,1'b0},
        {4'd5,3'd3,1'b0,1'b0,2'd0,2'd2,2'd1,2'd2,1'b0},
        {4'd5,3'd3,1'b0,1'b0,2'd0,2'd2,2'd0,2'd1,1'b0},
        {4'd5,3'd3,1'b0,1'b0,2'd0,2'd0,2'd0,2'd1,1'b0},
        // R6
        {4'd6,3'd4,1'b1,1'b1,2'd0,2'd0,2'd0,2'd2,1'b1},
        {4'd6,3'd4,1'b0,1'b1,2'd1,2'd0,2'd0,2'd2,1'b1},
        {4'd6,3'd4,1'b1,1'b0,2'd0,2'd1,2'd2,2'd1,1'b0},
        {4'd6,3'd4,1'b1,1'b0,2'd0,2'd0,2'd0,2'd2,1'b0},
        {4'd6,3'd4,1'b0,1'b0,2'd1,2'd1,2'd0,2'd1,1'b0},
        {4'd6,3'd4,1'b0,1'b0,2'd1,2'd0,2'd0,2'd0,1'b0},
        {4'd6,3'd4,1'b0,1'b0,2'd0,2'd0,2'd0,2'd0,1'b0},
        {4'd6,3'd4,1'b0,1'b0,2'd2,2'd0,2'd1,2'd2,1'b0},
        // R7
        {4'd7,3'd5,1'b0,1'b1,2'd0,2'd0,2'd0,2'd2,1'b0},
        {4'd7,3'd6,1'b0,1'b0,2'd0,2'd2,2'd1,2'd1,1'b0},
        {4'd7,3'd7,1'b1,1'b1,2'd1,2'd2,2'd0,2'd0,1'b0},
        {4'd7,3'd5,1'b0,1'b0,2'd0,2'd0,2'd0,2'd2,1'b0},
        // R8
        {4'd8,3'd0,1'b1,1'b0,2'd1,2'd1,2'd1,2'd2,1'b0},
        {4'd8,3'd1,1'b1,1'b0,2'd0,2'd1,2'd1,2'd1,1'b0},
        {4'd8,3'd3,1'b1,1'b0,2'd0,2'd2,2'd1,2'd2,1'b0},
        // R1
        {4'd1,3'd0,1'b0,1'b0,2'd3,2'd3,2'd1,2'd2,1'b0},
        {4'd1,3'd3,1'b0,1'b0,2'd3,2'd3,2'd3,2'd1,1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic fn, input logic iz,
                         input logic [1:0] a, input logic [1:0] b, input logic [1:0] c);
        mode = m; first_nan = fn; inf_zero = iz;
        cls_a = a; cls_b = b; cls_c = c;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; flag_clr = 1'b0;
        // invalid condition present during reset must not be collected
        drive(3'd1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0);
        repeat (3) @(negedge clk);
        #1 check("R11 sticky in reset", int'(invalid_sticky), 0);
        check("R9 invalid_now during reset", int'(invalid_now), 1);
        drive(3'd5, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        #1 check("R11 sticky after reset", int'(invalid_sticky), 0);

        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            @(negedge clk);
            v = VEC[i];
            drive(v[13:11], v[10], v[9], v[8:7], v[6:5], v[4:3]);
            #1;
            check($sformatf("R%0d vec %0d sel", v[17:14], i), int'(sel), int'(v[2:1]));
            check($sformatf("R%0d vec %0d inv", v[17:14], i), int'(invalid_now), int'(v[0]));
        end

        // clear whatever the table collected
        @(negedge clk);
        drive(3'd5, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); @(negedge clk); flag_clr = 1'b0;
        #1 check("R10 cleared", int'(invalid_sticky), 0);

        // R9 latency: invalid at one edge, sticky after the next
        @(negedge clk);
        drive(3'd2, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0);
        #1 check("R9 invalid_now same cycle", int'(invalid_now), 1);
        @(negedge clk);
        drive(3'd5, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0);
        #1 check("R9 sticky not yet", int'(invalid_sticky), 0);
        @(negedge clk);
        #1 check("R9 sticky set", int'(invalid_sticky), 1);
        repeat (4) @(negedge clk);
        #1 check("R10 sticky holds", int'(invalid_sticky), 1);

        // R10 plain clear
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        #1 check("R10 clear", int'(invalid_sticky), 0);

        // R10 collision: set sticky, then clear while a registered event is pending
        drive(3'd0, 1'b0, 1'b1, 2'd0, 2'd0, 2'd1);
        @(negedge clk);
        drive(3'd5, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0);
        @(negedge clk);
        #1 check("R10 sticky before collision", int'(invalid_sticky), 1);
        drive(3'd0, 1'b0, 1'b1, 2'd0, 2'd0, 2'd1);
        @(negedge clk);
        drive(3'd5, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0);
        flag_clr = 1'b1;
        @(negedge clk);
        #1 check("R10 set wins over clear", int'(invalid_sticky), 1);
        @(negedge clk);
        #1 check("R10 clear after collision", int'(invalid_sticky), 0);
        flag_clr = 1'b0;

        // R7 inf_zero never reaches the sticky flag in fallback modes
        drive(3'd6, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0);
        repeat (3) @(negedge clk);
        #1 check("R7 fallback sticky", int'(invalid_sticky), 0);

        // R11 reset clears a set flag
        drive(3'd1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0);
        repeat (3) @(negedge clk);
        drive(3'd5, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0);
        rst_n = 1'b0;
        #1 check("R11 async reset", int'(invalid_sticky), 0);
        @(negedge clk);
        rst_n = 1'b1;

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule